// File: doc/BRIEF.md
# Threaded-Code Inner Interpreter Sequencer

This block is a small byte-wide execution engine for a threaded-code (Forth-style) virtual machine. It keeps four 16-bit registers: a program counter, an instruction pointer into the current thread, a word pointer naming the word being run, and a pointer into a byte-addressed return stack that grows downward. It shares one 8-bit synchronous memory port with a 16-bit address, makes at most one access per cycle, and receives read data in the cycle after it presents the address.

Three opcodes are understood. The thread-advance opcode follows the next pointer in the thread. The colon-enter opcode saves the instruction pointer on the return stack and then advances into the thread of the word just entered. A short relative branch lets a primitive word do something observable. Every word header is one opcode byte followed by a pad byte, so a word's body starts two bytes past its header. Any other opcode stops the engine for good.

Top module: `tciSequencer`

## Requirements
- R1: A synchronous reset sets PC to START_PC, IP to START_IP, the return-stack pointer to START_RSP and W to 0, clears halt, and the first access after reset is an opcode read at START_PC.
- R2: Opcode 0x3B (thread advance) takes 3 cycles: an opcode read at PC, then reads at IP and IP+1, where the byte at IP is the low byte of a 16-bit pointer.
- R3: After 0x3B, W and PC hold the fetched pointer, IP has grown by 2, and the next access is an opcode read at the new PC.
- R4: Opcode 0x7B (colon enter) writes the high byte of IP at the return-stack pointer and, in the next cycle, the low byte at pointer minus 1; the pointer then ends 2 lower.
- R5: After its two writes, 0x7B reads a little-endian pointer at W+2 and W+3, sets IP to W+4, and loads W and PC with that pointer; the whole opcode takes 5 cycles.
- R6: Opcode 0x80 (branch) takes 2 cycles: an opcode read at PC and a read of a signed offset byte at PC+1; the next opcode read is at PC+2+offset (offset 0 gives PC+2). IP, W and the stack pointer are unchanged.
- R7: Any other opcode raises halt from the cycle after its decode; halt stays high until reset, no further read or write is made, and PC stays put.
- R8: memRd and memWe are never high together, and every cycle before a halt makes exactly one access.
- R9: The return-stack pointer wraps modulo 2^16: pushing from 0x0001 writes 0x0001 and 0x0000 and leaves 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| memAddr | output | 16 | Memory address for this cycle |
| memRd | output | 1 | Read strobe; data comes back next cycle |
| memWe | output | 1 | Write strobe |
| memWdata | output | 8 | Write data |
| memRdata | input | 8 | Read data for the previous cycle's read |
| halt | output | 1 | Sticky stop after an unknown opcode |
| pcOut | output | 16 | Program counter |
| ipOut | output | 16 | Instruction pointer |
| wOut | output | 16 | Word pointer |
| rspOut | output | 16 | Return-stack pointer |

## Verification
The bench builds two copies. The first starts at 0x0200 with IP 0x0202 and the stack pointer at 0x017F, running a thread step into a colon word, a push, a step into a primitive, zero, forward and backward branches and an unknown opcode. The second starts the stack pointer at 0x0001, so the two pushed bytes straddle address zero and the wrap of the pointer to 0xFFFF can be seen.

// File: rtl/tciPkg.sv
package tciPkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam logic [DATA_W-1:0] OP_NEXT  = 8'h3B;
  localparam logic [DATA_W-1:0] OP_ENTER = 8'h7B;
  localparam logic [DATA_W-1:0] OP_BRA   = 8'h80;
  localparam logic [ADDR_W-1:0] BODY_OFS = 16'd2;

  typedef enum logic [2:0] {
    A_FETCH, A_IP, A_IP1, A_RSP, A_RSP1, A_W2, A_W3, A_PC1
  } addrSel_t;

  typedef enum logic [1:0] {F_PC, F_PTR, F_BR} fetchSrc_t;

  typedef struct packed {
    addrSel_t  addrSel;
    logic      rd;
    logic      we;
    logic      wdHi;
    logic      fetch;
    fetchSrc_t fetchSrc;
    logic      latchLo;
    logic      ipInc2;
    logic      ipFromW4;
    logic      rspDec2;
  } ctl_t;
endpackage

// File: rtl/tciControl.sv
module tciControl
  import tciPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] memRdata,
  output ctl_t              ctl,
  output logic              halt
);
  typedef enum logic [2:0] {
    ST_FETCH, ST_OP, ST_NX2, ST_EN2, ST_EN3, ST_EN4, ST_HALT
  } state_t;

  state_t    state, nextState;
  fetchSrc_t pendSrc, nextPend;

  always_comb begin
    ctl          = '0;
    ctl.addrSel  = A_FETCH;
    ctl.fetchSrc = pendSrc;
    nextState    = state;
    nextPend     = pendSrc;
    case (state)
      ST_FETCH: begin
        ctl.rd    = 1'b1;
        ctl.fetch = 1'b1;
        nextPend  = F_PC;
        nextState = ST_OP;
      end
      ST_OP: begin
        case (memRdata)
          OP_NEXT: begin
            ctl.rd      = 1'b1;
            ctl.addrSel = A_IP;
            nextState   = ST_NX2;
          end
          OP_ENTER: begin
            ctl.we      = 1'b1;
            ctl.wdHi    = 1'b1;
            ctl.addrSel = A_RSP;
            nextState   = ST_EN2;
          end
          OP_BRA: begin
            ctl.rd      = 1'b1;
            ctl.addrSel = A_PC1;
            nextPend    = F_BR;
            nextState   = ST_FETCH;
          end
          default: nextState = ST_HALT;
        endcase
      end
      ST_NX2: begin
        ctl.rd      = 1'b1;
        ctl.addrSel = A_IP1;
        ctl.latchLo = 1'b1;
        ctl.ipInc2  = 1'b1;
        nextPend    = F_PTR;
        nextState   = ST_FETCH;
      end
      ST_EN2: begin
        ctl.we      = 1'b1;
        ctl.addrSel = A_RSP1;
        ctl.rspDec2 = 1'b1;
        nextState   = ST_EN3;
      end
      ST_EN3: begin
        ctl.rd      = 1'b1;
        ctl.addrSel = A_W2;
        nextState   = ST_EN4;
      end
      ST_EN4: begin
        ctl.rd       = 1'b1;
        ctl.addrSel  = A_W3;
        ctl.latchLo  = 1'b1;
        ctl.ipFromW4 = 1'b1;
        nextPend     = F_PTR;
        nextState    = ST_FETCH;
      end
      default: nextState = ST_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_FETCH;
      pendSrc <= F_PC;
    end else begin
      state   <= nextState;
      pendSrc <= nextPend;
    end
  end

  assign halt = (state == ST_HALT);

  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (rst)
    !(ctl.rd && ctl.we)); // R8
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    halt |=> halt); // R7
  AST_PUSH_ORDER: assert property (@(posedge clk) disable iff (rst)
    (ctl.we && ctl.wdHi) |=> (ctl.we && !ctl.wdHi)); // R4
endmodule

// File: rtl/tciDatapath.sv
module tciDatapath
  import tciPkg::*;
#(
  parameter logic [ADDR_W-1:0] START_PC  = 16'h0200,
  parameter logic [ADDR_W-1:0] START_IP  = 16'h0000,
  parameter logic [ADDR_W-1:0] START_RSP = 16'h0000
)(
  input  logic              clk,
  input  logic              rst,
  input  ctl_t              ctl,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] ip,
  output logic [ADDR_W-1:0] w,
  output logic [ADDR_W-1:0] rsp
);
  logic [DATA_W-1:0] loReg;
  logic [ADDR_W-1:0] ptrVal, brTarget, fetchAddr;

  assign ptrVal   = {memRdata, loReg};
  assign brTarget = pc + BODY_OFS + {{(ADDR_W-DATA_W){memRdata[DATA_W-1]}}, memRdata};

  always_comb begin
    case (ctl.fetchSrc)
      F_PTR:   fetchAddr = ptrVal;
      F_BR:    fetchAddr = brTarget;
      default: fetchAddr = pc;
    endcase
  end

  always_comb begin
    case (ctl.addrSel)
      A_IP:    memAddr = ip;
      A_IP1:   memAddr = ip + 16'd1;
      A_RSP:   memAddr = rsp;
      A_RSP1:  memAddr = rsp - 16'd1;
      A_W2:    memAddr = w + BODY_OFS;
      A_W3:    memAddr = w + BODY_OFS + 16'd1;
      A_PC1:   memAddr = pc + 16'd1;
      default: memAddr = (ctl.fetch) ? fetchAddr : '0;
    endcase
  end

  assign memWdata = ctl.wdHi ? ip[ADDR_W-1:DATA_W] : ip[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      pc    <= START_PC;
      ip    <= START_IP;
      w     <= '0;
      rsp   <= START_RSP;
      loReg <= '0;
    end else begin
      if (ctl.fetch) begin
        pc <= fetchAddr;
        if (ctl.fetchSrc == F_PTR) w <= ptrVal;
      end
      if (ctl.latchLo)  loReg <= memRdata;
      if (ctl.ipInc2)   ip <= ip + 16'd2;
      if (ctl.ipFromW4) ip <= w + BODY_OFS + 16'd2;
      if (ctl.rspDec2)  rsp <= rsp - 16'd2;
    end
  end

  AST_RSP_STEP: assert property (@(posedge clk) disable iff (rst)
    ctl.rspDec2 |=> (rsp == $past(rsp) - 16'd2)); // R9
  AST_PTR_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (ctl.fetch && ctl.fetchSrc == F_PTR) |=> (pc == w)); // R3
  AST_IP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    ctl.ipInc2 |=> (ip == $past(ip) + 16'd2)); // R3
endmodule

// File: rtl/tciSequencer.sv
module tciSequencer
  import tciPkg::*;
#(
  parameter logic [15:0] START_PC  = 16'h0200,
  parameter logic [15:0] START_IP  = 16'h0000,
  parameter logic [15:0] START_RSP = 16'h0000
)(
  input  logic        clk,
  input  logic        rst,
  output logic [15:0] memAddr,
  output logic        memRd,
  output logic        memWe,
  output logic [7:0]  memWdata,
  input  logic [7:0]  memRdata,
  output logic        halt,
  output logic [15:0] pcOut,
  output logic [15:0] ipOut,
  output logic [15:0] wOut,
  output logic [15:0] rspOut
);
  ctl_t ctl;

  tciControl uCtl (
    .clk(clk), .rst(rst), .memRdata(memRdata), .ctl(ctl), .halt(halt)
  );

  tciDatapath #(
    .START_PC(START_PC), .START_IP(START_IP), .START_RSP(START_RSP)
  ) uDp (
    .clk(clk), .rst(rst), .ctl(ctl), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata),
    .pc(pcOut), .ip(ipOut), .w(wOut), .rsp(rspOut)
  );

  assign memRd = ctl.rd;
  assign memWe = ctl.we;

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
    halt |-> (!memRd && !memWe)); // R7
  AST_HALT_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (halt && $past(halt)) |-> $stable(pcOut)); // R7
endmodule

// File: tb/tb_tciSequencer.sv
module tciTbMem (
  input  logic        clk,
  input  logic [15:0] addr,
  input  logic        rd,
  input  logic        we,
  input  logic [7:0]  wd,
  output logic [7:0]  rdata
);
  logic [7:0] mem [0:4095];
  always_ff @(posedge clk) begin
    if (we) mem[addr[11:0]] <= wd;
    if (rd) rdata <= mem[addr[11:0]];
  end
endmodule

module tb_tciSequencer;
  localparam int CLK_PERIOD = 10;
  localparam int NLOG = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [15:0] memAddr, pcOut, ipOut, wOut, rspOut;
  logic        memRd, memWe, halt;
  logic [7:0]  memWdata, memRdata;
  logic [15:0] memAddr2, pcOut2, ipOut2, wOut2, rspOut2;
  logic        memRd2, memWe2, halt2;
  logic [7:0]  memWdata2, memRdata2;

  tciSequencer #(.START_PC(16'h0200), .START_IP(16'h0202), .START_RSP(16'h017F)) dut (
    .clk(clk), .rst(rst), .memAddr(memAddr), .memRd(memRd), .memWe(memWe),
    .memWdata(memWdata), .memRdata(memRdata), .halt(halt),
    .pcOut(pcOut), .ipOut(ipOut), .wOut(wOut), .rspOut(rspOut));
  tciTbMem mem1 (.clk(clk), .addr(memAddr), .rd(memRd), .we(memWe),
    .wd(memWdata), .rdata(memRdata));

  tciSequencer #(.START_PC(16'h0200), .START_IP(16'h0202), .START_RSP(16'h0001)) dutWrap (
    .clk(clk), .rst(rst), .memAddr(memAddr2), .memRd(memRd2), .memWe(memWe2),
    .memWdata(memWdata2), .memRdata(memRdata2), .halt(halt2),
    .pcOut(pcOut2), .ipOut(ipOut2), .wOut(wOut2), .rspOut(rspOut2));
  tciTbMem mem2 (.clk(clk), .addr(memAddr2), .rd(memRd2), .we(memWe2),
    .wd(memWdata2), .rdata(memRdata2));

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [15:0] lAddr [0:NLOG-1];
  logic        lRd   [0:NLOG-1];
  logic        lWe   [0:NLOG-1];
  logic [7:0]  lWd   [0:NLOG-1];
  logic        lHalt [0:NLOG-1];
  logic [15:0] lPc   [0:NLOG-1];
  logic [15:0] lIp   [0:NLOG-1];
  logic [15:0] lW    [0:NLOG-1];
  logic [15:0] lRsp  [0:NLOG-1];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chkRead(input int k, input logic [15:0] a, input string req);
    chk(lRd[k] === 1'b1 && lWe[k] === 1'b0, req, $sformatf("read strobe cycle %0d", k),
        {lRd[k], lWe[k]}, 2'b10);
    chk(lAddr[k] === a, req, $sformatf("read address cycle %0d", k), lAddr[k], a);
  endtask

  task automatic chkWrite(input int k, input logic [15:0] a, input logic [7:0] d, input string req);
    chk(lWe[k] === 1'b1 && lRd[k] === 1'b0, req, $sformatf("write strobe cycle %0d", k),
        {lRd[k], lWe[k]}, 2'b01);
    chk(lAddr[k] === a, req, $sformatf("write address cycle %0d", k), lAddr[k], a);
    chk(lWd[k] === d, req, $sformatf("write data cycle %0d", k), lWd[k], d);
  endtask

  task automatic loadProgram();
    for (int i = 0; i < 4096; i++) begin
      mem1.mem[i] = 8'h00;
      mem2.mem[i] = 8'h00;
    end
    mem1.mem[12'h200] = 8'h3B; mem1.mem[12'h202] = 8'h05; mem1.mem[12'h203] = 8'h02;
    mem1.mem[12'h205] = 8'h7B; mem1.mem[12'h207] = 8'h0D; mem1.mem[12'h208] = 8'h02;
    mem1.mem[12'h20D] = 8'h80; mem1.mem[12'h20E] = 8'h00;
    mem1.mem[12'h20F] = 8'h80; mem1.mem[12'h210] = 8'h05;
    mem1.mem[12'h216] = 8'h80; mem1.mem[12'h217] = 8'hF9;
    mem1.mem[12'h211] = 8'hFF;
    for (int i = 12'h200; i < 12'h220; i++) mem2.mem[i] = mem1.mem[i];
  endtask

  task automatic testReset();
    chk(pcOut === 16'h0200, "R1", "reset pc", pcOut, 16'h0200);
    chk(ipOut === 16'h0202, "R1", "reset ip", ipOut, 16'h0202);
    chk(wOut === 16'h0000, "R1", "reset w", wOut, 16'h0000);
    chk(rspOut === 16'h017F, "R1", "reset rsp", rspOut, 16'h017F);
    chk(halt === 1'b0, "R1", "reset halt", halt, 1'b0);
  endtask

  task automatic capture();
    for (int k = 0; k < NLOG; k++) begin
      lAddr[k] = memAddr; lRd[k] = memRd; lWe[k] = memWe; lWd[k] = memWdata;
      lHalt[k] = halt; lPc[k] = pcOut; lIp[k] = ipOut; lW[k] = wOut; lRsp[k] = rspOut;
      @(negedge clk);
    end
  endtask

  task automatic testNext();
    chkRead(0, 16'h0200, "R1");
    chkRead(1, 16'h0202, "R2");
    chkRead(2, 16'h0203, "R2");
    chkRead(3, 16'h0205, "R3");
    chk(lIp[3] === 16'h0204, "R3", "ip after advance", lIp[3], 16'h0204);
    chk(lW[4] === 16'h0205, "R3", "w after advance", lW[4], 16'h0205);
    chk(lPc[4] === 16'h0205, "R3", "pc after advance", lPc[4], 16'h0205);
  endtask

  task automatic testEnter();
    chkWrite(4, 16'h017F, 8'h02, "R4");
    chkWrite(5, 16'h017E, 8'h04, "R4");
    chk(lRsp[6] === 16'h017D, "R4", "rsp after push", lRsp[6], 16'h017D);
    chkRead(6, 16'h0207, "R5");
    chkRead(7, 16'h0208, "R5");
    chkRead(8, 16'h020D, "R5");
    chk(lIp[8] === 16'h0209, "R5", "ip after enter", lIp[8], 16'h0209);
    chk(lW[9] === 16'h020D && lPc[9] === 16'h020D, "R5", "w/pc after enter",
        {lW[9], lPc[9]}, {16'h020D, 16'h020D});
    chk(mem1.mem[12'h17F] === 8'h02 && mem1.mem[12'h17E] === 8'h04, "R4",
        "stack bytes in memory", {mem1.mem[12'h17F], mem1.mem[12'h17E]}, 16'h0204);
  endtask

  task automatic testBranch();
    chkRead(9, 16'h020E, "R6");
    chkRead(10, 16'h020F, "R6");
    chkRead(11, 16'h0210, "R6");
    chkRead(12, 16'h0216, "R6");
    chkRead(13, 16'h0217, "R6");
    chkRead(14, 16'h0211, "R6");
    chk(lIp[15] === 16'h0209 && lW[15] === 16'h020D && lRsp[15] === 16'h017D, "R6",
        "ip/w/rsp kept by branch", {lIp[15], lW[15]}, {16'h0209, 16'h020D});
  endtask

  task automatic testAccessRule();
    bit ok = 1'b1;
    for (int k = 0; k < 15; k++)
      if ((lRd[k] ^ lWe[k]) !== 1'b1) ok = 1'b0;
    chk(ok, "R8", "exactly one access per cycle before halt", ok, 1'b1);
  endtask

  task automatic testIllegal();
    bit quiet = 1'b1;
    chk(lHalt[15] === 1'b0 && lHalt[16] === 1'b1, "R7", "halt rise timing",
        {lHalt[15], lHalt[16]}, 2'b01);
    for (int k = 15; k < NLOG; k++)
      if (lRd[k] !== 1'b0 || lWe[k] !== 1'b0) quiet = 1'b0;
    chk(quiet, "R7", "no access after unknown opcode", quiet, 1'b1);
    chk(lHalt[NLOG-1] === 1'b1 && lPc[NLOG-1] === 16'h0211, "R7", "halt sticky, pc held",
        lPc[NLOG-1], 16'h0211);
  endtask

  task automatic testWrap();
    chk(mem2.mem[12'h001] === 8'h02, "R9", "high byte at 0x0001", mem2.mem[12'h001], 8'h02);
    chk(mem2.mem[12'h000] === 8'h04, "R9", "low byte at 0x0000", mem2.mem[12'h000], 8'h04);
    chk(rspOut2 === 16'hFFFF, "R9", "rsp wrapped", rspOut2, 16'hFFFF);
    chk(ipOut2 === 16'h0209 && wOut2 === 16'h020D, "R9", "wrap copy ip/w",
        {ipOut2, wOut2}, {16'h0209, 16'h020D});
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    loadProgram();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    testReset();
    rst = 1'b0;
    capture();
    testNext();
    testEnter();
    testBranch();
    testAccessRule();
    testIllegal();
    testWrap();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule